// File: doc/BRIEF.md
# PCIe Slot Reset Timing Sequencer

This block brings a PCIe link partner out of reset after power-on. It drives the slot power enable, then the reference clock enable, holds the active-low slot reset output low until both the supply and the reference clock have been stable for their minimum times, releases the reset, and finally raises a flag telling the host that configuration requests may be issued. Each minimum time is measured from the moment the matching stable indication is seen high, not from the moment the enable was driven, so the unknown enable-to-stable latency of the board circuits never shortens a delay.

After reset release the block enforces a further 100 ms quiet period. When the root port advertises a maximum link speed above 5 GT/s, that period is anchored to the link-up indication instead of the reset release. The decision uses the advertised speed of this port, since the device below it is not known before enumeration. All delays are counted in cycles of a free-running clock whose frequency is a parameter, and every delay can be stretched by a per-board margin given in cycles. A loss of either stable indication aborts the sequence, and a start pulse while idle or finished restarts it.

Top module: `pcie_rst_seq`

## Requirements
- R1: Out of reset, slot_rst_n_o, pwr_en_o, refclk_en_o and cfg_ready_o are all 0, and they stay so until start_i is seen high.
- R2: start_i sampled high while idle or while cfg_ready_o is 1 makes, one cycle later, pwr_en_o=1, slot_rst_n_o=0, refclk_en_o=0 and cfg_ready_o=0; start_i in any other phase has no effect on the timing of the sequence.
- R3: refclk_en_o stays 0 while waiting for power and rises in the cycle after pwr_good_i is first sampled high in that wait.
- R4: slot_rst_n_o does not rise earlier than PWR_CYC cycles after the clock edge at which pwr_good_i was sampled high in the power wait, where PWR_CYC = ceil(CLK_HZ x 100 ms) + PWR_EXTRA_CYC.
- R5: slot_rst_n_o does not rise earlier than RC_CYC cycles after the edge at which refclk_good_i was sampled high in the clock wait, where RC_CYC = ceil(CLK_HZ x 100 us) + REFCLK_EXTRA_CYC.
- R6: slot_rst_n_o rises exactly at the later of the two limits of R4 and R5.
- R7: When max_speed_i is 2 or less (code 1 = 2.5 GT/s, 2 = 5 GT/s), cfg_ready_o rises exactly POST_CYC = ceil(CLK_HZ x 100 ms) + POST_EXTRA_CYC cycles after the edge at which slot_rst_n_o rose, whatever link_up_i does.
- R8: When max_speed_i is above 2 (3 = 8, 4 = 16, 5 = 32 GT/s), cfg_ready_o rises exactly POST_CYC cycles after the edge at which link_up_i is first sampled high after reset release, and not before.
- R9: If pwr_good_i or refclk_good_i is sampled low at any point after the clock enable was raised, the next cycle shows slot_rst_n_o=0, cfg_ready_o=0, refclk_en_o=0, pwr_en_o=1, and every timer restarts in full on the next entry to its wait.
- R10: cfg_ready_o is only ever 1 while slot_rst_n_o is 1, and slot_rst_n_o only rises when both stable inputs were high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart request, one cycle pulse |
| pwr_good_i | input | 1 | Slot supply is stable |
| refclk_good_i | input | 1 | Reference clock is stable |
| link_up_i | input | 1 | Link training has completed |
| max_speed_i | input | SPEED_W | Maximum link speed advertised by the root port (1 = 2.5 GT/s ... 5 = 32 GT/s) |
| pwr_en_o | output | 1 | Slot power enable |
| refclk_en_o | output | 1 | Reference clock enable |
| slot_rst_n_o | output | 1 | Active-low reset to the link partner |
| cfg_ready_o | output | 1 | Configuration requests may be issued |

## Verification
The bench builds the block with CLK_HZ = 50 000 and margins of 3, 2 and 4 cycles, which turns the 100 ms waits into 5003 and 5004 cycles and the 100 us wait into 7 cycles. That scaling keeps a full bring-up near ten thousand cycles, so a dozen complete sequences, including one where a very late clock-stable makes the short clock timer the limiting one, fit in a single run and every interval can be checked to the exact cycle. The non-zero margins make an omitted margin or an off-by-one in the rounding show up as a cycle-count mismatch.

// File: rtl/pcie_rst_seq_pkg.sv
package pcie_rst_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWR_WAIT,
      ST_CLK_WAIT,
      ST_TMR_WAIT,
      ST_LINK_WAIT,
      ST_POST_WAIT,
      ST_READY
   } seq_state_e;

   // Timer slots in the timer array
   localparam int TMR_PWR  = 0;
   localparam int TMR_RC   = 1;
   localparam int TMR_POST = 2;
   localparam int TMR_NUM  = 3;

   // Cycles covering a minimum time in microseconds, rounded up, plus margin
   function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                     longint unsigned us,
                                                     longint unsigned extra);
      return (hz * us + 64'd999_999) / 64'd1_000_000 + extra;
   endfunction

endpackage

// File: rtl/pcie_rst_seq_timer.sv
module pcie_rst_seq_timer #(
   parameter int              W   = 8,
   parameter longint unsigned LEN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic done_o
);

   logic [W-1:0] cnt_q;

   if (LEN < 1) begin : g_len_chk
      $error("pcie_rst_seq_timer: LEN must be at least 1");
   end
   if (LEN - 1 >= (64'd1 << W)) begin : g_w_chk
      $error("pcie_rst_seq_timer: W too small for LEN");
   end

   // Loaded with LEN-1: done is seen LEN cycles after the loading edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= W'(LEN - 1);
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pcie_rst_seq_speed.sv
module pcie_rst_seq_speed #(
   parameter int SPEED_W       = 3,
   parameter int SLOW_MAX_CODE = 2
) (
   input  logic [SPEED_W-1:0] speed_i,
   output logic               fast_o
);

   localparam logic [SPEED_W-1:0] THRESH = SPEED_W'(SLOW_MAX_CODE);

   if (SLOW_MAX_CODE >= (1 << SPEED_W)) begin : g_thr_chk
      $error("pcie_rst_seq_speed: SLOW_MAX_CODE does not fit SPEED_W");
   end

   assign fast_o = (speed_i > THRESH);

endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq #(
   parameter int unsigned CLK_HZ           = 100_000_000,
   parameter int unsigned PWR_MIN_US       = 100_000,
   parameter int unsigned REFCLK_MIN_US    = 100,
   parameter int unsigned POST_MIN_US      = 100_000,
   parameter int unsigned PWR_EXTRA_CYC    = 0,
   parameter int unsigned REFCLK_EXTRA_CYC = 0,
   parameter int unsigned POST_EXTRA_CYC   = 0,
   parameter int          SPEED_W          = 3,
   parameter int          SLOW_MAX_CODE    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               pwr_good_i,
   input  logic               refclk_good_i,
   input  logic               link_up_i,
   input  logic [SPEED_W-1:0] max_speed_i,
   output logic               pwr_en_o,
   output logic               refclk_en_o,
   output logic               slot_rst_n_o,
   output logic               cfg_ready_o
);

   import pcie_rst_seq_pkg::*;

   localparam longint unsigned PWR_CYC  = us_to_cycles(CLK_HZ, PWR_MIN_US, PWR_EXTRA_CYC);
   localparam longint unsigned RC_CYC   = us_to_cycles(CLK_HZ, REFCLK_MIN_US, REFCLK_EXTRA_CYC);
   localparam longint unsigned POST_CYC = us_to_cycles(CLK_HZ, POST_MIN_US, POST_EXTRA_CYC);
   localparam longint unsigned MAX_A    = (PWR_CYC > RC_CYC) ? PWR_CYC : RC_CYC;
   localparam longint unsigned MAX_CYC  = (MAX_A > POST_CYC) ? MAX_A : POST_CYC;
   localparam int              CW       = $clog2(MAX_CYC + 1);

   if (CLK_HZ == 0) begin : g_hz_chk
      $error("pcie_rst_seq: CLK_HZ must be non-zero");
   end
   if (PWR_MIN_US == 0 || REFCLK_MIN_US == 0 || POST_MIN_US == 0) begin : g_us_chk
      $error("pcie_rst_seq: minimum delays must be non-zero");
   end
   if (SPEED_W < 2) begin : g_sw_chk
      $error("pcie_rst_seq: SPEED_W must be at least 2");
   end

   seq_state_e          state_q, state_d;
   logic [TMR_NUM-1:0]  tmr_load, tmr_run, tmr_done;
   logic                fast_port;
   logic                stable_lost;
   logic                pwr_lost;

   // Speed class of this port
   pcie_rst_seq_speed #(
      .SPEED_W       (SPEED_W),
      .SLOW_MAX_CODE (SLOW_MAX_CODE)
   ) u_speed (
      .speed_i (max_speed_i),
      .fast_o  (fast_port)
   );

   // One down-counter per minimum delay
   for (genvar gi = 0; gi < TMR_NUM; gi++) begin : g_tmr
      localparam longint unsigned TLEN = (gi == TMR_PWR) ? PWR_CYC :
                                         (gi == TMR_RC)  ? RC_CYC  : POST_CYC;
      pcie_rst_seq_timer #(
         .W   (CW),
         .LEN (TLEN)
      ) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (tmr_load[gi]),
         .run_i  (tmr_run[gi]),
         .done_o (tmr_done[gi])
      );
   end

   assign pwr_lost    = !pwr_good_i;
   assign stable_lost = !pwr_good_i || !refclk_good_i;

   // Timer control: each timer reloads on entry to the wait it guards
   always_comb begin
      tmr_load = '0;
      tmr_run  = '0;
      tmr_load[TMR_PWR]  = (state_q == ST_PWR_WAIT) && pwr_good_i;
      tmr_run[TMR_PWR]   = (state_q == ST_CLK_WAIT) || (state_q == ST_TMR_WAIT);
      tmr_load[TMR_RC]   = (state_q == ST_CLK_WAIT) && pwr_good_i && refclk_good_i;
      tmr_run[TMR_RC]    = (state_q == ST_TMR_WAIT);
      tmr_load[TMR_POST] = ((state_q == ST_TMR_WAIT) && !stable_lost &&
                            tmr_done[TMR_PWR] && tmr_done[TMR_RC] && !fast_port) ||
                           ((state_q == ST_LINK_WAIT) && !stable_lost && link_up_i);
      tmr_run[TMR_POST]  = (state_q == ST_POST_WAIT);
   end

   // Sequencing
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) state_d = ST_PWR_WAIT;
         end
         ST_PWR_WAIT: begin
            if (pwr_good_i) state_d = ST_CLK_WAIT;
         end
         ST_CLK_WAIT: begin
            if (pwr_lost)           state_d = ST_PWR_WAIT;
            else if (refclk_good_i) state_d = ST_TMR_WAIT;
         end
         ST_TMR_WAIT: begin
            if (stable_lost)
               state_d = ST_PWR_WAIT;
            else if (tmr_done[TMR_PWR] && tmr_done[TMR_RC])
               state_d = fast_port ? ST_LINK_WAIT : ST_POST_WAIT;
         end
         ST_LINK_WAIT: begin
            if (stable_lost)    state_d = ST_PWR_WAIT;
            else if (link_up_i) state_d = ST_POST_WAIT;
         end
         ST_POST_WAIT: begin
            if (stable_lost)              state_d = ST_PWR_WAIT;
            else if (tmr_done[TMR_POST])  state_d = ST_READY;
         end
         ST_READY: begin
            if (stable_lost || start_i) state_d = ST_PWR_WAIT;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // Output decode from the registered state
   always_comb begin
      pwr_en_o     = (state_q != ST_IDLE);
      refclk_en_o  = (state_q == ST_CLK_WAIT) || (state_q == ST_TMR_WAIT) ||
                     (state_q == ST_LINK_WAIT) || (state_q == ST_POST_WAIT) ||
                     (state_q == ST_READY);
      slot_rst_n_o = (state_q == ST_LINK_WAIT) || (state_q == ST_POST_WAIT) ||
                     (state_q == ST_READY);
      cfg_ready_o  = (state_q == ST_READY);
   end

endmodule

// File: rtl/pcie_rst_seq_chk.sv
module pcie_rst_seq_chk #(
   parameter longint unsigned PWR_CYC  = 10,
   parameter longint unsigned RC_CYC   = 10,
   parameter longint unsigned POST_CYC = 10
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic pwr_good_i,
   input logic refclk_good_i,
   input logic pwr_en_o,
   input logic refclk_en_o,
   input logic slot_rst_n_o,
   input logic cfg_ready_o
);

   localparam int AW = $clog2(PWR_CYC + RC_CYC + POST_CYC + 3);
   localparam logic [AW-1:0] PG_SAT = AW'(PWR_CYC + 1);
   localparam logic [AW-1:0] RC_SAT = AW'(RC_CYC + 1);
   localparam logic [AW-1:0] RS_SAT = AW'(POST_CYC + 1);

   logic [AW-1:0] pg_age, rc_age, rs_age;

   // Saturating ages of the stable inputs and of the released reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_age <= '0;
         rc_age <= '0;
         rs_age <= '0;
      end else begin
         pg_age <= !pwr_good_i    ? '0 : (pg_age < PG_SAT) ? pg_age + 1'b1 : pg_age;
         rc_age <= !refclk_good_i ? '0 : (rc_age < RC_SAT) ? rc_age + 1'b1 : rc_age;
         rs_age <= !slot_rst_n_o  ? '0 : (rs_age < RS_SAT) ? rs_age + 1'b1 : rs_age;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en_o |-> (!refclk_en_o && !slot_rst_n_o && !cfg_ready_o));

   a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ready_o && start_i) |=> (!slot_rst_n_o && !cfg_ready_o && pwr_en_o));

   a_r3_clk_after_power: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refclk_en_o) |-> $past(pwr_good_i));

   a_r4_power_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_rst_n_o) |-> (pg_age > AW'(PWR_CYC)));

   a_r5_refclk_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_rst_n_o) |-> (rc_age > AW'(RC_CYC)));

   a_r7_post_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_ready_o) |-> (rs_age >= AW'(POST_CYC)));

   a_r9_power_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (refclk_en_o && !pwr_good_i) |=> (!slot_rst_n_o && !cfg_ready_o && !refclk_en_o));

   a_r9_clock_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_rst_n_o && !refclk_good_i) |=> (!slot_rst_n_o && !cfg_ready_o));

   a_r10_ready_in_release: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready_o |-> slot_rst_n_o);

   a_r10_release_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_rst_n_o) |-> $past(pwr_good_i && refclk_good_i));

endmodule

bind pcie_rst_seq pcie_rst_seq_chk #(
   .PWR_CYC  (PWR_CYC),
   .RC_CYC   (RC_CYC),
   .POST_CYC (POST_CYC)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .pwr_good_i    (pwr_good_i),
   .refclk_good_i (refclk_good_i),
   .pwr_en_o      (pwr_en_o),
   .refclk_en_o   (refclk_en_o),
   .slot_rst_n_o  (slot_rst_n_o),
   .cfg_ready_o   (cfg_ready_o)
);

// File: tb/sim_pcie_rst_seq.sv
module sim_pcie_rst_seq;

   localparam int unsigned HZ    = 50_000;
   localparam int unsigned PX    = 3;
   localparam int unsigned RX    = 2;
   localparam int unsigned QX    = 4;

   // Expected interval lengths from the requirement formulas
   function automatic int cyc_of(int unsigned hz, int unsigned us, int unsigned extra);
      longint unsigned p;
      p = longint'(hz) * longint'(us);
      return int'((p + 999_999) / 1_000_000) + int'(extra);
   endfunction

   localparam int E_PWR  = cyc_of(HZ, 100_000, PX);
   localparam int E_RC   = cyc_of(HZ, 100, RX);
   localparam int E_POST = cyc_of(HZ, 100_000, QX);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       pwr_good = 1'b0;
   logic       refclk_good = 1'b0;
   logic       link_up = 1'b0;
   logic [2:0] max_speed = 3'd1;
   logic       pwr_en, refclk_en, slot_rst_n, cfg_ready;

   int checks = 0;
   int fails  = 0;
   int nidx   = 0;
   bit ended  = 1'b0;

   always #5 clk = ~clk;

   pcie_rst_seq #(
      .CLK_HZ           (HZ),
      .PWR_EXTRA_CYC    (PX),
      .REFCLK_EXTRA_CYC (RX),
      .POST_EXTRA_CYC   (QX)
   ) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start),
      .pwr_good_i    (pwr_good),
      .refclk_good_i (refclk_good),
      .link_up_i     (link_up),
      .max_speed_i   (max_speed),
      .pwr_en_o      (pwr_en),
      .refclk_en_o   (refclk_en),
      .slot_rst_n_o  (slot_rst_n),
      .cfg_ready_o   (cfg_ready)
   );

   task automatic tick();
      @(negedge clk);
      nidx++;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, nidx);
      end
   endtask

   function automatic int exp_release(input int tp, input int tc);
      return ((tp + E_PWR) > (tc + E_RC) ? (tp + E_PWR) : (tc + E_RC)) + 1;
   endfunction

   function automatic int exp_ready(input bit fast, input int r, input int tl);
      return fast ? (tl + E_POST + 1) : (r + E_POST);
   endfunction

   // One bring-up; hold keeps the plant signals high and restarts from ready
   task automatic run_seq(input int speed, input int dp, input int dc, input int dl,
                          input bit drop_mid, input bit hold);
      int  tp, tc, tl, r, rd, guard;
      bit  was_ready, fast, early;
      fast  = (speed > 2);
      early = 1'b0;
      if (!hold) begin
         was_ready   = cfg_ready;
         pwr_good    = 1'b0;
         refclk_good = 1'b0;
         link_up     = 1'b0;
         tick();
         if (was_ready)
            chk(!slot_rst_n && !cfg_ready && pwr_en && !refclk_en,
                "R9 drop from ready", {slot_rst_n, cfg_ready, pwr_en, refclk_en}, 4'b0010);
      end
      max_speed = 3'(speed);
      start = 1'b1;
      tick();
      start = 1'b0;
      chk(pwr_en && !slot_rst_n && !cfg_ready && !refclk_en, "R2 start",
          {pwr_en, slot_rst_n, cfg_ready, refclk_en}, 4'b1000);
      if (hold) begin
         tp = nidx;
         tc = nidx + 1;
      end else begin
         for (int i = 0; i < dp; i++) begin
            tick();
            if (refclk_en) early = 1'b1;
         end
         chk(!early && !refclk_en, "R3 clock enable held", refclk_en, 0);
         pwr_good = 1'b1;
         tp = nidx;
         tick();
         chk(refclk_en, "R3 clock enable after power", refclk_en, 1);
         for (int i = 0; i < dc; i++) tick();
         refclk_good = 1'b1;
         tc = nidx;
         if (drop_mid) begin
            for (int i = 0; i < 20; i++) tick();
            refclk_good = 1'b0;
            tick();
            chk(!slot_rst_n && !refclk_en && pwr_en && !cfg_ready, "R9 clock drop",
                {slot_rst_n, refclk_en, pwr_en, cfg_ready}, 4'b0010);
            tp = nidx;
            tick();
            for (int i = 0; i < dc; i++) tick();
            refclk_good = 1'b1;
            tc = nidx;
            for (int i = 0; i < 3; i++) tick();
            start = 1'b1;   // R2: must be ignored here
            tick();
            start = 1'b0;
         end
      end
      guard = 0;
      while (!slot_rst_n && guard < 20_000) begin
         if (cfg_ready) early = 1'b1;
         tick();
         guard++;
      end
      r = nidx;
      chk(r == exp_release(tp, tc),
          (tc + E_RC > tp + E_PWR) ? "R5 R6 release (clock limited)" : "R4 R6 release (power limited)",
          r - tp, exp_release(tp, tc) - tp);
      chk(!early && !cfg_ready, "R10 ready before release", cfg_ready, 0);
      if (hold) begin
         tl = r;
      end else begin
         for (int i = 0; i < dl; i++) tick();
         link_up = 1'b1;
         tl = nidx;
      end
      guard = 0;
      while (!cfg_ready && guard < 20_000) begin
         tick();
         guard++;
      end
      rd = nidx;
      chk(rd == exp_ready(fast, r, tl), fast ? "R8 ready after link" : "R7 ready after release",
          rd - r, exp_ready(fast, r, tl) - r);
   endtask

   initial begin
      void'($urandom(32'h1c3a_55e1));
      rst_n = 1'b0;
      tick();
      chk(!pwr_en && !refclk_en && !slot_rst_n && !cfg_ready, "R1 reset state",
          {pwr_en, refclk_en, slot_rst_n, cfg_ready}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) tick();
      chk(!pwr_en && !slot_rst_n, "R1 idle without start", {pwr_en, slot_rst_n}, 0);

      run_seq(2, 4, 3, 30, 1'b0, 1'b0);    // 5 GT/s boundary: slow anchor
      run_seq(3, 0, 0, 40, 1'b0, 1'b0);    // 8 GT/s boundary: link anchor
      run_seq(1, 2, 5100, 10, 1'b0, 1'b0); // clock timer limits release
      run_seq(4, 6, 9, 25, 1'b1, 1'b0);    // clock drop and ignored start
      run_seq(5, 0, 0, 0, 1'b0, 1'b1);     // restart from ready, signals held
      for (int k = 0; k < 6; k++) begin
         run_seq($urandom_range(5, 1), $urandom_range(15, 0), $urandom_range(15, 0),
                 $urandom_range(50, 0), 1'b0, 1'b0);
      end
      pwr_good = 1'b0;
      tick();
      chk(!slot_rst_n && !cfg_ready && !refclk_en && pwr_en, "R9 power drop",
          {slot_rst_n, cfg_ready, refclk_en, pwr_en}, 1);

      if (!ended) begin
         ended = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (195_000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=0", nidx);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule